// File: doc/BRIEF.md
# NAND Flash Host Register Interface

This block sits on a processor's register bus and turns register accesses into pin cycles for one 8-bit NAND flash device. A write to the command register makes a command-latch cycle on the flash pins. A write to the address register makes an address-latch cycle. A write to the data register makes a plain byte write. A read of the data register makes a read-strobe cycle and returns the byte sampled from the flash data lines. Every cycle has three phases: setup, strobe and hold. The length of each phase comes from a timing register, so software can match the cycle to slower or faster devices.

Software selects the device by clearing the active-low chip-enable bit in the control register. It enables the sequencer with a separate bit. The ready/busy line from the flash passes through a synchronizer. The status register shows its live level and a sticky flag that is set when the line goes from busy to ready. Software clears that flag by writing one to it. While a pin cycle runs, the bus ready output stays low, so the processor stalls until the cycle completes.

Top module: `nand_host_regif`

## Requirements
- R1: After reset, the timing register reads 0x00007770, the control register reads 0x00000002 and the status register reads 0. fl_ce_n is high, fl_we_n and fl_re_n are high, and fl_cle, fl_ale and fl_dq_oe are low.
- R2: The timing register (word offset 0x00) keeps setup length in bits 14:12, strobe width in bits 10:8 and hold length in bits 6:4. All other bits read as 0.
- R3: The control register (offset 0x04) has the enable in bit 0 and the active-low chip enable in bit 1. Bit 1 drives fl_ce_n directly.
- R4: When enabled, a write to offset 0x08 makes a cycle with fl_cle high and fl_ale low. fl_we_n is low and fl_dq_out equals wdata[7:0] during the strobe phase.
- R5: When enabled, a write to offset 0x0C makes the same kind of cycle with fl_ale high and fl_cle low.
- R6: When enabled, a read of offset 0x10 pulses fl_re_n low for the strobe phase. The read returns, in bits 7:0, the fl_dq_in byte sampled in the last strobe cycle.
- R7: A pin cycle has setup+1 cycles before the strobe, strobe+1 cycles of strobe and hold+1 cycles after it. The strobe is asserted only in the middle phase.
- R8: bus_ready stays low from the start of a pin cycle to its end. It is high for one cycle after the hold phase.
- R9: Status bit 0 shows the level of fl_rb two clock edges after the pin changes.
- R10: Status bit 2 is set by a low-to-high change of the synchronized fl_rb. It stays set until a write to offset 0x20 with bit 2 set. A write with bit 2 clear leaves it unchanged.
- R11: While the enable bit is 0, accesses to offsets 0x08, 0x0C and 0x10 complete at once and cause no strobe, latch or drive activity.
- R12: When enabled, a write to offset 0x10 pulses fl_we_n with both fl_cle and fl_ale low, and drives wdata[7:0] on fl_dq_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request, held until bus_ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completes on the clock edge where bus_sel and bus_ready are both high |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Command-latch enable |
| fl_ale | output | 1 | Address-latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_out | output | 8 | Byte driven toward the flash |
| fl_dq_oe | output | 1 | Output enable for fl_dq_out |
| fl_dq_in | input | 8 | Byte from the flash |
| fl_rb | input | 1 | Flash ready/busy, high = ready |

## Verification
The bench sweeps timing settings from all-zero to all-seven over each kind of access. It counts the setup, strobe and hold cycles at the pins. An off-by-one in a phase counter would show up as a phase one cycle too short or too long. The bench also checks the latch lines against the access type and the byte on the data lines. A swapped command/address latch, or a read byte taken from the wrong cycle, would fail these checks. Status is sampled one edge after fl_rb changes and again after the second edge, so a synchronizer that is too short or too long is caught. The sticky flag is written with zero and then with one: a design that clears on any write, or never clears, would fail. Finally, pin accesses are issued with the enable off, and any stray strobe would be reported.

// File: rtl/nhr_pkg.sv
// Package: shared constants and types for the NAND host register interface.
// Assumes a 32-bit register bus addressed in bytes, with word-aligned registers.
package nhr_pkg;

    // Word indices (byte offset divided by four).
    localparam logic [3:0] REG_CFG = 4'h0;
    localparam logic [3:0] REG_CTL = 4'h1;
    localparam logic [3:0] REG_CMD = 4'h2;
    localparam logic [3:0] REG_ADR = 4'h3;
    localparam logic [3:0] REG_DAT = 4'h4;
    localparam logic [3:0] REG_STA = 4'h8;

    // Bit positions of the timing fields in the config register.
    localparam int CFG_SETUP_LSB  = 12;
    localparam int CFG_STROBE_LSB = 8;
    localparam int CFG_HOLD_LSB   = 4;

    // Bit positions in the control and status registers.
    localparam int CTL_EN_BIT     = 0;
    localparam int CTL_CEN_BIT    = 1;
    localparam int STA_LIVE_BIT   = 0;
    localparam int STA_RISE_BIT   = 2;

    // Kinds of pin cycle.
    typedef enum logic [1:0] {
        OPK_CMD  = 2'd0,
        OPK_ADDR = 2'd1,
        OPK_DATA = 2'd2
    } op_kind_t;

    // Phases of the pin sequencer.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_DONE   = 3'd4
    } phase_t;

endpackage

// File: rtl/nand_rb_detect.sv
// Ready/busy detector: passes the asynchronous ready/busy pin through a
// SYNC-stage flop chain, gives out the synchronized level, and keeps a sticky
// flag set on each low-to-high transition. A clear request drops the flag,
// but a rise in the same cycle wins.
// Assumes SYNC >= 2.
module nand_rb_detect #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_pin,
    input  logic clr,
    output logic live,
    output logic sticky
);
    logic [SYNC-1:0] sync_q;
    logic            prev_q;
    logic            rise;

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC-2:0], rb_pin};
    end

    assign live = sync_q[SYNC-1];
    assign rise = live & ~prev_q;

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= live;
    end

    // Sticky rise flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   sticky <= 1'b0;
        else if (rise) sticky <= 1'b1;
        else if (clr)  sticky <= 1'b0;
    end
endmodule

// File: rtl/nand_pin_seq.sv
// Pin sequencer: runs one flash bus cycle made of setup, strobe and hold
// phases. Each phase lasts its programmed length plus one clock. The write or
// read strobe is asserted only in the strobe phase. A read samples the input
// byte in the last strobe cycle. A one-cycle done phase follows the hold
// phase. Assumes the timing inputs stay stable while a cycle runs.
module nand_pin_seq
    import nhr_pkg::*;
#(
    parameter int TW = 3,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  op_kind_t      kind_i,
    input  logic          rd_i,
    input  logic [BW-1:0] wbyte_i,
    input  logic [TW-1:0] setup_len,
    input  logic [TW-1:0] strobe_len,
    input  logic [TW-1:0] hold_len,
    input  logic [BW-1:0] din,
    output logic          idle,
    output logic          done,
    output logic [BW-1:0] rbyte,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic          dq_oe,
    output logic [BW-1:0] dq_out
);
    phase_t        ph_q;
    logic [TW-1:0] cnt_q;
    op_kind_t      kind_q;
    logic          rd_q;
    logic [BW-1:0] wbyte_q;
    logic          active;
    logic          last;

    assign last = (cnt_q == '0);

    // Phase state and the down-counter for the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (start) begin
                    ph_q  <= PH_SETUP;
                    cnt_q <= setup_len;
                end
                PH_SETUP: if (last) begin
                    ph_q  <= PH_STROBE;
                    cnt_q <= strobe_len;
                end else cnt_q <= cnt_q - 1'b1;
                PH_STROBE: if (last) begin
                    ph_q  <= PH_HOLD;
                    cnt_q <= hold_len;
                end else cnt_q <= cnt_q - 1'b1;
                PH_HOLD: if (last) ph_q <= PH_DONE;
                         else      cnt_q <= cnt_q - 1'b1;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Capture the access kind and write byte when a cycle begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= OPK_DATA;
            rd_q    <= 1'b0;
            wbyte_q <= '0;
        end else if (ph_q == PH_IDLE && start) begin
            kind_q  <= kind_i;
            rd_q    <= rd_i;
            wbyte_q <= wbyte_i;
        end
    end

    // Sample the flash byte in the last strobe cycle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) rbyte <= '0;
        else if (ph_q == PH_STROBE && last && rd_q) rbyte <= din;
    end

    assign active = (ph_q == PH_SETUP) || (ph_q == PH_STROBE) || (ph_q == PH_HOLD);
    assign idle   = (ph_q == PH_IDLE);
    assign done   = (ph_q == PH_DONE);
    assign cle    = active && (kind_q == OPK_CMD);
    assign ale    = active && (kind_q == OPK_ADDR);
    assign we_n   = !((ph_q == PH_STROBE) && !rd_q);
    assign re_n   = !((ph_q == PH_STROBE) && rd_q);
    assign dq_oe  = active && !rd_q;
    assign dq_out = wbyte_q;
endmodule

// File: rtl/nand_csr.sv
// Register file: holds the timing fields, the enable and the chip-enable
// bits, and builds the read-back word for any register index.
// Assumes 4*3 field spacing fits TW (TW <= 4) and a 32-bit bus.
module nand_csr
    import nhr_pkg::*;
#(
    parameter int TW    = 3,
    parameter int BW    = 8,
    parameter int DW    = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    input  logic             live,
    input  logic             sticky,
    input  logic [BW-1:0]    rbyte,
    output logic [TW-1:0]    setup_len,
    output logic [TW-1:0]    strobe_len,
    output logic [TW-1:0]    hold_len,
    output logic             en,
    output logic             ce_n,
    output logic [DW-1:0]    rdata
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata[DW-1:16], wdata[3:2]};

    // Timing and control registers; timing resets to the slowest setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_len  <= '1;
            strobe_len <= '1;
            hold_len   <= '1;
            en         <= 1'b0;
            ce_n       <= 1'b1;
        end else if (wr_en) begin
            if (idx == REG_CFG) begin
                setup_len  <= wdata[CFG_SETUP_LSB  +: TW];
                strobe_len <= wdata[CFG_STROBE_LSB +: TW];
                hold_len   <= wdata[CFG_HOLD_LSB   +: TW];
            end
            if (idx == REG_CTL) begin
                en   <= wdata[CTL_EN_BIT];
                ce_n <= wdata[CTL_CEN_BIT];
            end
        end
    end

    // Read-back multiplexer.
    always_comb begin
        rdata = '0;
        case (idx)
            REG_CFG: begin
                rdata[CFG_SETUP_LSB  +: TW] = setup_len;
                rdata[CFG_STROBE_LSB +: TW] = strobe_len;
                rdata[CFG_HOLD_LSB   +: TW] = hold_len;
            end
            REG_CTL: begin
                rdata[CTL_EN_BIT]  = en;
                rdata[CTL_CEN_BIT] = ce_n;
            end
            REG_DAT: rdata[BW-1:0] = rbyte;
            REG_STA: begin
                rdata[STA_LIVE_BIT] = live;
                rdata[STA_RISE_BIT] = sticky;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/nand_host_regif.sv
// Top: decodes register-bus accesses, starts pin cycles for command,
// address and data accesses while the enable bit is set, stalls the bus
// during a pin cycle, and wires the ready/busy detector into status.
// Assumes the master holds bus_sel, bus_wr, bus_addr and bus_wdata stable
// until the edge where bus_ready is high.
module nand_host_regif
    import nhr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int TW     = 3,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              fl_ce_n,
    output logic              fl_cle,
    output logic              fl_ale,
    output logic              fl_we_n,
    output logic              fl_re_n,
    output logic [7:0]        fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [7:0]        fl_dq_in,
    input  logic              fl_rb
);
    localparam int BW    = 8;
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             unused_abits;
    logic [TW-1:0]    setup_len, strobe_len, hold_len;
    logic             en_q, ce_n_q;
    logic             rb_live, rb_sticky, sta_clr;
    logic             is_pin_wr, is_pin_rd, pin_acc;
    logic             seq_idle, seq_done, seq_start;
    logic [BW-1:0]    rbyte;
    op_kind_t         kind;

    assign idx          = bus_addr[ADDR_W-1:2];
    assign unused_abits = ^bus_addr[1:0];

    // Access decode: which accesses need a pin cycle.
    assign is_pin_wr = bus_wr && (idx == REG_CMD || idx == REG_ADR || idx == REG_DAT);
    assign is_pin_rd = !bus_wr && (idx == REG_DAT);
    assign pin_acc   = bus_sel && en_q && (is_pin_wr || is_pin_rd);
    assign seq_start = pin_acc && seq_idle;
    assign bus_ready = bus_sel && (!pin_acc || seq_done);
    assign sta_clr   = bus_sel && bus_wr && (idx == REG_STA) && bus_wdata[STA_RISE_BIT];

    // Map the register index to a pin-cycle kind.
    always_comb begin
        case (idx)
            REG_CMD: kind = OPK_CMD;
            REG_ADR: kind = OPK_ADDR;
            default: kind = OPK_DATA;
        endcase
    end

    nand_csr #(.TW(TW), .BW(BW), .DW(DATA_W), .IDX_W(IDX_W)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_sel && bus_wr),
        .idx        (idx),
        .wdata      (bus_wdata),
        .live       (rb_live),
        .sticky     (rb_sticky),
        .rbyte      (rbyte),
        .setup_len  (setup_len),
        .strobe_len (strobe_len),
        .hold_len   (hold_len),
        .en         (en_q),
        .ce_n       (ce_n_q),
        .rdata      (bus_rdata)
    );

    nand_pin_seq #(.TW(TW), .BW(BW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (seq_start),
        .kind_i     (kind),
        .rd_i       (!bus_wr),
        .wbyte_i    (bus_wdata[BW-1:0]),
        .setup_len  (setup_len),
        .strobe_len (strobe_len),
        .hold_len   (hold_len),
        .din        (fl_dq_in),
        .idle       (seq_idle),
        .done       (seq_done),
        .rbyte      (rbyte),
        .cle        (fl_cle),
        .ale        (fl_ale),
        .we_n       (fl_we_n),
        .re_n       (fl_re_n),
        .dq_oe      (fl_dq_oe),
        .dq_out     (fl_dq_out)
    );

    nand_rb_detect #(.SYNC(SYNC)) u_rb (
        .clk    (clk),
        .rst_n  (rst_n),
        .rb_pin (fl_rb),
        .clr    (sta_clr),
        .live   (rb_live),
        .sticky (rb_sticky)
    );

    assign fl_ce_n = ce_n_q;
endmodule

// File: rtl/nand_host_regif_chk.sv
// Checker: temporal properties of the NAND host register interface,
// attached to every instance of the top through bind.
module nand_host_regif_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_ready,
    input logic fl_cle,
    input logic fl_ale,
    input logic fl_we_n,
    input logic fl_re_n,
    input logic en_q,
    input logic sticky,
    input logic sta_clr
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_re_n)); // R7

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_cle && fl_ale)); // R5

    AST_READ_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_re_n |-> (!fl_cle && !fl_ale)); // R6

    AST_STALL_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_re_n) |-> !bus_ready); // R8

    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (fl_we_n && fl_re_n && !fl_cle && !fl_ale)); // R11

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !sta_clr) |=> sticky); // R10
endmodule

bind nand_host_regif nand_host_regif_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ready (bus_ready),
    .fl_cle    (fl_cle),
    .fl_ale    (fl_ale),
    .fl_we_n   (fl_we_n),
    .fl_re_n   (fl_re_n),
    .en_q      (en_q),
    .sticky    (rb_sticky),
    .sta_clr   (sta_clr)
);

// File: tb/sim_nand_host_regif.sv
// Bench: walks a vector table of timing settings and access kinds, then runs
// directed tests for reset, masking, chip enable, ready/busy and disable.
module sim_nand_host_regif;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {setup[18:16], strobe[15:13], hold[12:10], op[9:8], byte[7:0]}
    // op: 0 command write, 1 address write, 2 data write, 3 data read
    localparam logic [18:0] VEC [NVEC] = '{
        {3'd0, 3'd0, 3'd0, 2'd0, 8'hFF},
        {3'd1, 3'd2, 3'd0, 2'd1, 8'h3C},
        {3'd2, 3'd0, 3'd3, 2'd2, 8'hA5},
        {3'd0, 3'd3, 3'd1, 2'd3, 8'h5A},
        {3'd7, 3'd7, 3'd7, 2'd0, 8'h30},
        {3'd3, 3'd1, 3'd2, 2'd1, 8'h00},
        {3'd4, 3'd4, 3'd0, 2'd3, 8'hC3},
        {3'd0, 3'd0, 3'd5, 2'd2, 8'h81}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
    logic [7:0]  fl_dq_out;
    logic [7:0]  fl_dq_in = '0;
    logic        fl_rb = 1'b0;
    int          total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_host_regif u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .fl_ce_n(fl_ce_n), .fl_cle(fl_cle),
        .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_rb(fl_rb)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic pin_op(input logic [5:0] a, input logic w, input logic [7:0] b,
                          output int pre, output int str, output int post,
                          output logic cle_seen, output logic ale_seen,
                          output logic [7:0] drv, output logic [7:0] rd);
        pre = 0; str = 0; post = 0; cle_seen = 0; ale_seen = 0; drv = '0; rd = '0;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = {24'h0, b};
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (bus_ready) begin
                rd = bus_rdata[7:0];
                break;
            end
            if (fl_cle) cle_seen = 1'b1;
            if (fl_ale) ale_seen = 1'b1;
            if (!fl_we_n || !fl_re_n) begin
                str++;
                if (!fl_we_n) drv = fl_dq_out;
            end else if (str == 0) pre++;
            else post++;
        end
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int pre, str, post;
        logic cs, as;
        logic [7:0] drv, rd;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        reg_rd(6'h00, d); chk("R1 cfg reset", d, 32'h0000_7770);
        reg_rd(6'h04, d); chk("R1 ctl reset", d, 32'h0000_0002);
        reg_rd(6'h20, d); chk("R1 status reset", d, 32'h0);
        chk("R1 pins idle", {fl_ce_n, fl_we_n, fl_re_n, fl_cle, fl_ale, fl_dq_oe}, 6'b111000);

        // R2: unused config bits read as zero
        reg_wr(6'h00, 32'hFFFF_FFFF);
        reg_rd(6'h00, d); chk("R2 cfg mask", d, 32'h0000_7770);

        // R3: chip enable follows control bit 1
        reg_wr(6'h04, 32'h1);
        chk("R3 ce selected", fl_ce_n, 1'b0);

        // Vector table walk: R4 R5 R6 R7 R8 R12
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] s, t, h;
            logic [1:0] op;
            logic [7:0] b;
            logic [5:0] a;
            {s, t, h, op, b} = VEC[v];
            a = (op == 2'd0) ? 6'h08 : (op == 2'd1) ? 6'h0C : 6'h10;
            reg_wr(6'h00, (32'(s) << 12) | (32'(t) << 8) | (32'(h) << 4));
            reg_rd(6'h00, d);
            chk("R2 cfg readback", d, (32'(s) << 12) | (32'(t) << 8) | (32'(h) << 4));
            fl_dq_in = b;
            pin_op(a, (op != 2'd3), b, pre, str, post, cs, as, drv, rd);
            chk("R7 setup cycles", pre, 32'(s) + 1);
            chk("R7 strobe cycles", str, 32'(t) + 1);
            chk("R7 hold cycles", post, 32'(h) + 1);
            chk("R8 stall length", pre + str + post, 32'(s) + 32'(t) + 32'(h) + 3);
            chk("R4 cle only on command", cs, (op == 2'd0));
            chk("R5 ale only on address", as, (op == 2'd1));
            if (op == 2'd3) chk("R6 read byte", rd, b);
            else if (op == 2'd2) chk("R12 data write byte", drv, b);
            else if (op == 2'd1) chk("R5 address byte", drv, b);
            else chk("R4 command byte", drv, b);
            fl_dq_in = 8'h00;
        end

        // R9 / R10: ready/busy synchronizer and sticky rise flag
        @(negedge clk); fl_rb = 1'b1;
        reg_rd(6'h20, d); chk("R9 level after one edge", d[0], 1'b0);
        reg_rd(6'h20, d); chk("R9 level after two edges", d[0], 1'b1);
        reg_rd(6'h20, d); chk("R10 rise latched", d[2], 1'b1);
        reg_wr(6'h20, 32'h0);
        @(negedge clk); fl_rb = 1'b0;
        repeat (4) @(posedge clk);
        reg_rd(6'h20, d); chk("R10 zero write keeps flag", d, 32'h4);
        reg_wr(6'h20, 32'h4);
        reg_rd(6'h20, d); chk("R10 one write clears flag", d, 32'h0);

        // R11: disabled controller makes no pin activity
        reg_wr(6'h04, 32'h2);
        chk("R3 ce released", fl_ce_n, 1'b1);
        pin_op(6'h08, 1'b1, 8'h70, pre, str, post, cs, as, drv, rd);
        chk("R11 no strobe when disabled", str, 0);
        chk("R11 no latch when disabled", {cs, as}, 2'b00);
        chk("R11 immediate ready", pre + post, 0);
        pin_op(6'h10, 1'b0, 8'h00, pre, str, post, cs, as, drv, rd);
        chk("R11 no read strobe when disabled", str, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule